// File: doc/BRIEF.md
# Auto-Reload PWM Timer with Input Capture

This block is an 8-bit up-counter that restarts from a programmable reload value each time it passes its top count of 255. The counter is clocked either by the system clock through a power-of-two prescaler, with division from 1 to 128, or by rising edges on an external event input. One reload value sets the period of all four PWM outputs, and so sets their resolution too. Each output has its own duty value, output enable and polarity. A duty value written by software is used only from the next wrap of the counter, so a period already in progress is never cut short.

Two input-capture channels copy the counter value when their pin shows the selected edge. Each channel can raise an interrupt. When the counter runs from the external input, the overflow flag marks that a programmed number of external events has occurred. Software uses the block through a simple 8-bit register bus with a single-cycle write strobe and a combinational read.

Register map: 0 control, 1 counter, 2 reload, 3 PWM control, 4 to 7 duty of channels 0 to 3, 8 capture control, 9 and 10 captured values of channels 0 and 1.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset every register reads 0, every PWM output is low, and both interrupt outputs are low.
- R2: While the enable bit (control bit 3) is set and the external select bit (control bit 7) is clear, the counter advances by one every 2^S system clocks, where S is control bits 6:4 (0 to 7). A write to the control register restarts the prescaler.
- R3: Address 1 reads the live counter. A write to it loads the counter and takes priority over a count in the same cycle.
- R4: When the counter advances from 255, it loads the reload register (address 2) and sets the overflow flag (control bit 0). Writing 1 to bit 0 clears the flag. The overflow interrupt output is the flag ANDed with control bit 1.
- R5: A channel's raw waveform is high while counter >= its active duty value. With reload R and duty D, the period is 256-R counts. The waveform is high for 256-D of those counts when D > R, and for the whole period when D <= R.
- R6: PWM control bits 3:0 enable outputs 0 to 3, and a cleared bit holds its output low. Bits 7:4 invert the raw waveform of channels 0 to 3.
- R7: A duty register (address 4+i) is copied into channel i's active compare value only when the counter wraps. Between wraps the output keeps following the old value.
- R8: With control bit 7 set, the counter advances once per rising edge of the external clock input, seen after a two-flop synchronizer. Starting from the reload value, the overflow flag sets after 256-R edges.
- R9: On the selected edge of a synchronized capture pin, the capture register of that channel (address 9 or 10) latches the counter. The channel's flag (capture control bit 4+j, write 1 to clear) sets, and the capture interrupt is high while any flag has its enable bit (capture control bit 2+j) set. Capture control bit j set selects the rising edge, clear selects the falling edge.
- R10: An edge opposite to the selected one neither changes the capture register nor sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 8 | Read data of the addressed register |
| extClk | input | 1 | External event clock |
| capPin | input | 2 | Input-capture pins |
| pwmOut | output | 4 | PWM outputs |
| irqOvf | output | 1 | Overflow interrupt |
| irqCap | output | 1 | Capture interrupt |

## Verification
The PWM path is driven with a table of reload, duty, polarity and channel sets, and the high cycles are counted over one full period. The duty values in the table lie above, equal to and below the reload value, and include the top count. This separates the normal compare from the saturated case, the single-count edge case and the inverted waveform, and shows that each channel acts on its own. Directed sequences then check three things: the prescaler rate at two division settings, a counter wrap landing on the reload value, and a duty change that must stay hidden until the next wrap. They also count external edges one short of overflow and exactly to it, and drive capture pins with both the selected and the opposite edge.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int CNT_W   = 8;
  localparam int PRESC_W = 7;
  localparam int SEL_W   = $clog2(PRESC_W + 1);

  typedef struct packed {
    logic             cntWr;
    logic [CNT_W-1:0] cntData;
    logic             prescClr;
  } art_strobe_t;
endpackage

// File: rtl/art_ctrl.sv
module art_ctrl
  import art_pkg::*;
#(
  parameter int NUM_PWM = 4,
  parameter int NUM_CAP = 2,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [CNT_W-1:0]                busWdata,
  input  logic                            busWe,
  output logic [CNT_W-1:0]                busRdata,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_CAP-1:0][CNT_W-1:0]   capVal,
  input  logic                            ovfEvent,
  input  logic [NUM_CAP-1:0]              capEvent,
  output art_strobe_t                     strb,
  output logic                            extSel,
  output logic [SEL_W-1:0]                prescSel,
  output logic                            cntEn,
  output logic [CNT_W-1:0]                reload,
  output logic [NUM_PWM-1:0][CNT_W-1:0]   duty,
  output logic [NUM_PWM-1:0]              oe,
  output logic [NUM_PWM-1:0]              pol,
  output logic [NUM_CAP-1:0]              capRise,
  output logic                            irqOvf,
  output logic                            irqCap
);
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_CNT    = 1;
  localparam int ADDR_RELOAD = 2;
  localparam int ADDR_PWMCTL = 3;
  localparam int DUTY_BASE   = 4;
  localparam int ADDR_CAPCTL = DUTY_BASE + NUM_PWM;
  localparam int CAP_BASE    = ADDR_CAPCTL + 1;
  localparam int CAPCFG_W    = 2 * NUM_CAP;

  logic                  ovfIe, ovfFlag;
  logic [2*NUM_PWM-1:0]  pwmCtl;
  logic [CAPCFG_W-1:0]   capCfg;
  logic [NUM_CAP-1:0]    capFlag;
  logic                  wrCtrl, wrCnt, wrReload, wrPwm, wrCapCtl;
  logic [NUM_PWM-1:0]    wrDuty;

  always_comb begin
    wrCtrl   = busWe && (busAddr == ADDR_W'(ADDR_CTRL));
    wrCnt    = busWe && (busAddr == ADDR_W'(ADDR_CNT));
    wrReload = busWe && (busAddr == ADDR_W'(ADDR_RELOAD));
    wrPwm    = busWe && (busAddr == ADDR_W'(ADDR_PWMCTL));
    wrCapCtl = busWe && (busAddr == ADDR_W'(ADDR_CAPCTL));
    for (int i = 0; i < NUM_PWM; i++)
      wrDuty[i] = busWe && (busAddr == ADDR_W'(DUTY_BASE + i));
  end

  always_comb begin
    strb.cntWr    = wrCnt;
    strb.cntData  = busWdata;
    strb.prescClr = wrCtrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extSel   <= 1'b0;
      prescSel <= '0;
      cntEn    <= 1'b0;
      ovfIe    <= 1'b0;
      ovfFlag  <= 1'b0;
      reload   <= '0;
      pwmCtl   <= '0;
      duty     <= '0;
      capCfg   <= '0;
      capFlag  <= '0;
    end else begin
      if (wrCtrl) begin
        extSel   <= busWdata[7];
        prescSel <= busWdata[6:4];
        cntEn    <= busWdata[3];
        ovfIe    <= busWdata[1];
      end
      if (ovfEvent)                    ovfFlag <= 1'b1;
      else if (wrCtrl && busWdata[0])  ovfFlag <= 1'b0;
      if (wrReload) reload <= busWdata;
      if (wrPwm)    pwmCtl <= busWdata[2*NUM_PWM-1:0];
      for (int i = 0; i < NUM_PWM; i++)
        if (wrDuty[i]) duty[i] <= busWdata;
      if (wrCapCtl) capCfg <= busWdata[CAPCFG_W-1:0];
      for (int j = 0; j < NUM_CAP; j++) begin
        if (capEvent[j])                             capFlag[j] <= 1'b1;
        else if (wrCapCtl && busWdata[CAPCFG_W + j]) capFlag[j] <= 1'b0;
      end
    end
  end

  assign oe      = pwmCtl[NUM_PWM-1:0];
  assign pol     = pwmCtl[2*NUM_PWM-1:NUM_PWM];
  assign capRise = capCfg[NUM_CAP-1:0];
  assign irqOvf  = ovfFlag & ovfIe;
  assign irqCap  = |(capFlag & capCfg[CAPCFG_W-1:NUM_CAP]);

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL))
      busRdata = {extSel, prescSel, cntEn, 1'b0, ovfIe, ovfFlag};
    else if (busAddr == ADDR_W'(ADDR_CNT))
      busRdata = cnt;
    else if (busAddr == ADDR_W'(ADDR_RELOAD))
      busRdata = reload;
    else if (busAddr == ADDR_W'(ADDR_PWMCTL))
      busRdata = CNT_W'(pwmCtl);
    else if (busAddr == ADDR_W'(ADDR_CAPCTL))
      busRdata = CNT_W'({capFlag, capCfg});
    for (int i = 0; i < NUM_PWM; i++)
      if (busAddr == ADDR_W'(DUTY_BASE + i)) busRdata = duty[i];
    for (int j = 0; j < NUM_CAP; j++)
      if (busAddr == ADDR_W'(CAP_BASE + j)) busRdata = capVal[j];
  end

  // R4
  ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovfEvent |=> ovfFlag);

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_capChk
    // R9
    cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capEvent[j] |=> capFlag[j]);
  end
endmodule

// File: rtl/art_datapath.sv
module art_datapath
  import art_pkg::*;
#(
  parameter int NUM_PWM     = 4,
  parameter int NUM_CAP     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  art_strobe_t                   strb,
  input  logic                          extSel,
  input  logic [SEL_W-1:0]              prescSel,
  input  logic                          cntEn,
  input  logic [CNT_W-1:0]              reload,
  input  logic [NUM_PWM-1:0][CNT_W-1:0] duty,
  input  logic [NUM_PWM-1:0]            oe,
  input  logic [NUM_PWM-1:0]            pol,
  input  logic [NUM_CAP-1:0]            capRise,
  input  logic                          extClk,
  input  logic [NUM_CAP-1:0]            capPin,
  output logic [CNT_W-1:0]              cnt,
  output logic [NUM_CAP-1:0][CNT_W-1:0] capVal,
  output logic                          ovfEvent,
  output logic [NUM_CAP-1:0]            capEvent,
  output logic [NUM_PWM-1:0]            pwmOut
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [PRESC_W-1:0]           presc, prescMask;
  logic                         intTick, extTick, tick;
  logic [SYNC_STAGES-1:0]       extSync;
  logic                         extPrev;
  logic [NUM_PWM-1:0][CNT_W-1:0] activeDuty;

  // prescaler: tick when the low S bits are all ones
  always_comb begin
    for (int b = 0; b < PRESC_W; b++)
      prescMask[b] = (b < int'(prescSel));
  end
  assign intTick = ((presc & prescMask) == prescMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                presc <= '0;
    else if (strb.prescClr)    presc <= '0;
    else if (cntEn && !extSel) presc <= presc + PRESC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      extSync <= {extSync[SYNC_STAGES-2:0], extClk};
      extPrev <= extSync[SYNC_STAGES-1];
    end
  end
  assign extTick = extSync[SYNC_STAGES-1] & ~extPrev;

  assign tick     = cntEn & (extSel ? extTick : intTick);
  assign ovfEvent = tick & ~strb.cntWr & (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (strb.cntWr) cnt <= strb.cntData;
    else if (tick)       cnt <= (cnt == TOP) ? reload : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        activeDuty <= '0;
    else if (ovfEvent) activeDuty <= duty;
  end

  for (genvar i = 0; i < NUM_PWM; i++) begin : g_pwm
    logic raw;
    assign raw       = (cnt >= activeDuty[i]);
    assign pwmOut[i] = oe[i] & (raw ^ pol[i]);
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    logic [SYNC_STAGES-1:0] pinSync;
    logic                   pinPrev, pinNow;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pinSync <= '0;
        pinPrev <= 1'b0;
      end else begin
        pinSync <= {pinSync[SYNC_STAGES-2:0], capPin[j]};
        pinPrev <= pinSync[SYNC_STAGES-1];
      end
    end
    assign pinNow      = pinSync[SYNC_STAGES-1];
    assign capEvent[j] = capRise[j] ? (pinNow & ~pinPrev) : (~pinNow & pinPrev);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           capVal[j] <= '0;
      else if (capEvent[j]) capVal[j] <= cnt;
    end
    // R9
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capEvent[j] |=> capVal[j] == $past(cnt));
  end

  // R4
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovfEvent |=> cnt == $past(reload));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !strb.cntWr && cnt != TOP) |=> cnt == $past(cnt) + CNT_W'(1));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntWr |=> cnt == $past(strb.cntData));
  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovfEvent |=> $stable(activeDuty));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import art_pkg::*;
#(
  parameter int NUM_PWM     = 4,
  parameter int NUM_CAP     = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CNT_W-1:0]   busWdata,
  input  logic               busWe,
  output logic [CNT_W-1:0]   busRdata,
  input  logic               extClk,
  input  logic [NUM_CAP-1:0] capPin,
  output logic [NUM_PWM-1:0] pwmOut,
  output logic               irqOvf,
  output logic               irqCap
);
  art_strobe_t                   strb;
  logic                          extSel, cntEn, ovfEvent;
  logic [SEL_W-1:0]              prescSel;
  logic [CNT_W-1:0]              reload, cnt;
  logic [NUM_PWM-1:0][CNT_W-1:0] duty;
  logic [NUM_PWM-1:0]            oe, pol;
  logic [NUM_CAP-1:0]            capRise, capEvent;
  logic [NUM_CAP-1:0][CNT_W-1:0] capVal;

  art_ctrl #(.NUM_PWM(NUM_PWM), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .cnt(cnt), .capVal(capVal),
    .ovfEvent(ovfEvent), .capEvent(capEvent), .strb(strb), .extSel(extSel),
    .prescSel(prescSel), .cntEn(cntEn), .reload(reload), .duty(duty),
    .oe(oe), .pol(pol), .capRise(capRise), .irqOvf(irqOvf), .irqCap(irqCap)
  );

  art_datapath #(.NUM_PWM(NUM_PWM), .NUM_CAP(NUM_CAP), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .extSel(extSel), .prescSel(prescSel),
    .cntEn(cntEn), .reload(reload), .duty(duty), .oe(oe), .pol(pol),
    .capRise(capRise), .extClk(extClk), .capPin(capPin), .cnt(cnt),
    .capVal(capVal), .ovfEvent(ovfEvent), .capEvent(capEvent), .pwmOut(pwmOut)
  );
endmodule

// File: tb/pwm_reload_timer_tb.sv
module pwm_reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic       extClk = 1'b0;
  logic [1:0] capPin = '0;
  logic [3:0] pwmOut;
  logic       irqOvf, irqCap;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .extClk(extClk), .capPin(capPin),
    .pwmOut(pwmOut), .irqOvf(irqOvf), .irqCap(irqCap)
  );

  // {channel, reload, duty, polarity, expected high cycles per period}
  localparam int VEC [8][5] = '{
    '{0,   0, 128, 0, 128},
    '{1,   0,  64, 1,  64},
    '{2, 200, 250, 0,   6},
    '{3, 200, 100, 0,  56},
    '{0, 200, 100, 1,   0},
    '{1, 250, 255, 0,   1},
    '{2, 250, 250, 0,   6},
    '{3, 128, 192, 1,  64}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busAddr = 4'(a); busWdata = 8'(d); busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    busAddr = 4'(a);
    #1;
    d = int'(busRdata);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic extPulse();
    extClk = 1'b1; cycles(3);
    extClk = 1'b0; cycles(3);
  endtask

  initial begin
    int a, b, hi, n, ch;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    for (int r = 0; r < 11; r++) begin
      rd(r, a);
      chk("R1 register reset", a, 0);
    end
    chk("R1 pwm reset", int'(pwmOut), 0);
    chk("R1 irq reset", int'({irqOvf, irqCap}), 0);

    // R5 R6 vector table
    for (int v = 0; v < 8; v++) begin
      ch = VEC[v][0];
      n  = 256 - VEC[v][1];
      wr(0, 0);
      wr(2, VEC[v][1]);
      wr(4 + ch, VEC[v][2]);
      wr(3, (1 << ch) | (VEC[v][3] << (ch + 4)));
      wr(1, 255);
      wr(0, 8'h08);
      cycles(3);
      hi = 0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (pwmOut[ch]) hi++;
      end
      chk($sformatf("R5 R6 vector %0d high count", v), hi, VEC[v][4]);
    end

    // R3 counter load and read
    wr(0, 0);
    wr(1, 10);
    rd(1, a);
    chk("R3 counter write readback", a, 10);

    // R2 prescaler rates
    wr(0, 8'h08);
    rd(1, a); cycles(5); rd(1, b);
    chk("R2 divide by 1", (b - a) & 255, 5);
    wr(0, 8'h38);
    rd(1, a); cycles(32); rd(1, b);
    chk("R2 divide by 8", (b - a) & 255, 4);

    // R4 wrap to reload, flag, interrupt
    wr(0, 0);
    wr(2, 8'hF0);
    wr(1, 8'hFE);
    wr(0, 8'h0A);
    cycles(2);
    rd(1, a);
    chk("R4 wrap loads reload", a, 8'hF0);
    rd(0, a);
    chk("R4 flag set", a & 1, 1);
    chk("R4 irq high", int'(irqOvf), 1);
    wr(0, 8'h03);
    rd(0, a);
    chk("R4 flag cleared", a & 1, 0);
    chk("R4 irq low", int'(irqOvf), 0);

    // R7 duty copied only at wrap
    wr(0, 0);
    wr(2, 0);
    wr(4, 50);
    wr(3, 8'h01);
    wr(1, 255);
    wr(0, 8'h08);
    cycles(2);
    wr(0, 0);
    wr(1, 100);
    chk("R5 compare above duty", int'(pwmOut[0]), 1);
    wr(4, 200);
    chk("R7 new duty held back", int'(pwmOut[0]), 1);
    wr(1, 255);
    wr(0, 8'h08);
    wr(0, 0);
    wr(1, 100);
    chk("R7 new duty after wrap", int'(pwmOut[0]), 0);
    wr(3, 8'h11);
    chk("R6 polarity inverts", int'(pwmOut[0]), 1);
    wr(3, 8'h10);
    chk("R6 disabled output low", int'(pwmOut), 0);

    // R8 external event counting
    wr(0, 8'h01);
    wr(2, 8'hFD);
    wr(1, 8'hFD);
    wr(0, 8'h8A);
    extPulse(); extPulse();
    rd(1, a);
    chk("R8 two edges counted", a, 8'hFF);
    rd(0, a);
    chk("R8 no event before count", a & 1, 0);
    cycles(10);
    rd(1, a);
    chk("R8 system clock ignored", a, 8'hFF);
    extPulse();
    rd(1, a);
    chk("R8 third edge wraps", a, 8'hFD);
    rd(0, a);
    chk("R8 event flag after 3 edges", a & 1, 1);

    // R9 R10 input capture
    wr(0, 8'h01);
    wr(1, 8'h42);
    wr(8, 8'h0D);
    capPin[0] = 1'b1; cycles(4);
    rd(9, a);
    chk("R9 rising capture value", a, 8'h42);
    rd(8, a);
    chk("R9 capture flag 0", a, 8'h1D);
    chk("R9 capture irq", int'(irqCap), 1);
    wr(8, 8'h1D);
    chk("R9 irq after clear", int'(irqCap), 0);
    wr(1, 8'h55);
    capPin[0] = 1'b0; cycles(4);
    rd(9, a);
    chk("R10 falling edge ignored on ch0", a, 8'h42);
    rd(8, a);
    chk("R10 no flag on ch0", a, 8'h0D);
    wr(1, 8'h77);
    capPin[1] = 1'b1; cycles(4);
    rd(8, a);
    chk("R10 rising edge ignored on ch1", a, 8'h0D);
    capPin[1] = 1'b0; cycles(4);
    rd(10, a);
    chk("R9 falling capture value", a, 8'h77);
    rd(8, a);
    chk("R9 capture flag 1", a, 8'h2D);
    chk("R9 capture irq ch1", int'(irqCap), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule